// File: doc/BRIEF.md
# Round-Robin Endpoint Transfer Scheduler

This block owns a small set of endpoint contexts for a full-speed host and decides which endpoint gets the next bus transaction. Software-side logic loads a transfer onto an endpoint through a command port, either as a control transfer or as a bulk transfer, with a direction, a byte count, a maximum packet size and a starting data toggle. The scheduler then visits the endpoints that hold a live transfer in circular order. It hands one transaction request at a time to a separate transaction engine, takes back that engine's result code, updates the endpoint's context and reports a finished transfer with a status code. Packet data never passes through the block.

A control transfer is the one exception to strict rotation. Once its SETUP stage is acknowledged, the data stage (or the status stage, for a zero-length transfer) is requested at once on the same endpoint. If that follow-on is NAKed, the rest waits for the endpoint's next turn. STALL, or a run of consecutive transaction errors, halts the endpoint and drops it from the rotation until a fresh transfer is loaded.

Both the command port and the request port use valid/ready. A request, once raised, keeps `req_valid` and all its fields unchanged until `req_ready` is seen. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. Results and completions have no back-pressure: the engine pulses `res_valid` once per accepted request, and the consumer must take `done_valid` on the cycle it is high.

Top module: `ep_rr_sched`

## Requirements
- R1: After every transaction, except an acknowledged SETUP, the next request goes to the first live endpoint found in ascending circular order after the endpoint just served. After reset the search starts at endpoint 0.
- R2: When a SETUP (`req_pid`=2, toggle 0, length 8) is acknowledged (`res_code`=0), the very next request is on the same endpoint. It is the data stage with toggle 1 in the transfer direction, or a status stage IN (`req_pid`=1) with toggle 1 when the transfer length is zero.
- R3: A NAK (`res_code`=1) on a non-SETUP transaction gives no completion, and the endpoint is retried on its next turn. A NAK on SETUP ends the transfer with status 3 and does not halt the endpoint.
- R4: Every acknowledged data-stage transaction inverts the endpoint's toggle. A toggle-mismatch result (`res_code`=3) leaves the toggle and the remaining length unchanged.
- R5: OUT requests (`req_pid`=0) carry min(remaining, max packet). The data stage ends when nothing remains. IN requests carry the max packet size, and the stage ends on a short packet (`res_len` < max) or once `res_len` covers the remaining count. A bulk transfer then completes with status 0. A control transfer moves to a zero-length status stage with toggle 1 in the opposite direction (IN if there was no data stage), and completes with status 0 when that stage is acknowledged.
- R6: STALL (`res_code`=2) ends the transfer with status 1, sets the endpoint's bit in `ep_halted` and removes it from the rotation.
- R7: Result codes 4 and above are transaction errors. ERR_LIMIT (3) of them in a row end the transfer with status 2 and halt the endpoint. An ACK, a NAK or a toggle mismatch clears the run.
- R8: Loading a new transfer on a halted endpoint clears its halted bit and returns it to the rotation.
- R9: Unlink (`cmd_op`=1) on a live endpoint that is not the one currently requested or awaiting a result completes one cycle later with status 4. On the endpoint in flight, the result is discarded and status 4 is reported one cycle after that result arrives.
- R10: While no endpoint is live, `req_valid` stays low.
- R11: Enqueue (`cmd_op`=0) is accepted only on an endpoint with no live transfer. `cmd_ready` is low in any cycle where `res_valid` is high. Unlink on an endpoint with no live transfer is accepted and changes nothing.
- R12: While `req_valid` is high and `req_ready` low, the request and its fields hold steady.
- R13: After reset no request and no completion is raised, no endpoint is halted and enqueue is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 1 | 0 enqueue, 1 unlink |
| cmd_ep | input | EP_W | Target endpoint |
| cmd_ctrl | input | 1 | 1 control transfer, 0 bulk |
| cmd_dir_in | input | 1 | 1 data flows device to host |
| cmd_toggle | input | 1 | Starting toggle for bulk transfers |
| cmd_len | input | LEN_W | Transfer byte count |
| cmd_mps | input | MPS_W | Maximum packet size |
| req_valid | output | 1 | Transaction request raised |
| req_ready | input | 1 | Engine takes the request |
| req_ep | output | EP_W | Endpoint of the request |
| req_pid | output | 2 | 0 OUT, 1 IN, 2 SETUP |
| req_toggle | output | 1 | Data toggle to use |
| req_len | output | MPS_W | Bytes to send (OUT/SETUP) or accept (IN) |
| res_valid | input | 1 | Result of the accepted request |
| res_code | input | 4 | 0 ACK, 1 NAK, 2 STALL, 3 toggle mismatch, 4 and up error |
| res_len | input | MPS_W | Bytes received on IN |
| done_valid | output | 1 | Transfer finished |
| done_ep | output | EP_W | Endpoint of the finished transfer |
| done_status | output | 3 | 0 ok, 1 stall, 2 protocol error, 3 SETUP NAK, 4 unlinked |
| ep_halted | output | N_EP | Halted flag per endpoint |

## Verification
Directed runs first walk one bulk OUT transfer interleaved with a control IN transfer. This separates strict rotation from the control follow-on and from a deferred NAKed data stage. An error, toggle-mismatch and error sequence is used to tell a consecutive-error count from a total count. A STALL on the status stage, a SETUP NAK and unlinks of both an idle and an in-flight endpoint each separate halting, non-halting and discarded outcomes. A long seeded random run then mixes result codes, short and full IN packets, random ready delays and random commands arriving during a transaction, so that endpoint choice, toggle, length and completion status are all compared against a reference model at every transaction.

// File: rtl/ep_rr_sched_pkg.sv
package ep_rr_sched_pkg;
  localparam int LEN_W = 16;
  localparam int MPS_W = 11;
  localparam int ERR_W = 4;
  localparam int SETUP_BYTES = 8;

  localparam logic [1:0] PID_OUT   = 2'd0;
  localparam logic [1:0] PID_IN    = 2'd1;
  localparam logic [1:0] PID_SETUP = 2'd2;

  localparam logic [3:0] RC_ACK    = 4'd0;
  localparam logic [3:0] RC_NAK    = 4'd1;
  localparam logic [3:0] RC_STALL  = 4'd2;
  localparam logic [3:0] RC_TOGERR = 4'd3;

  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_STALL    = 3'd1;
  localparam logic [2:0] ST_PROTO    = 3'd2;
  localparam logic [2:0] ST_SETUPNAK = 3'd3;
  localparam logic [2:0] ST_UNLINKED = 3'd4;

  localparam logic OP_ENQ    = 1'b0;
  localparam logic OP_UNLINK = 1'b1;

  typedef enum logic [1:0] {PH_SETUP = 2'd0, PH_DATA = 2'd1, PH_STATUS = 2'd2} phase_e;

  typedef struct packed {
    logic             active;
    logic             halted;
    logic             is_ctrl;
    logic             dir_in;
    logic             nodata;
    logic             toggle;
    phase_e           phase;
    logic [ERR_W-1:0] errs;
    logic [LEN_W-1:0] rem;
    logic [MPS_W-1:0] mps;
  } ctx_t;
endpackage

// File: rtl/ep_rr_pick.sv
module ep_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] sel
);
  always_comb begin
    any = |elig;
    sel = last;
    for (int k = N; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (elig[idx]) sel = IW'(idx);
    end
  end
endmodule

// File: rtl/ep_rr_txn.sv
module ep_rr_txn
  import ep_rr_sched_pkg::*;
#(
  parameter int ERR_LIMIT = 3
) (
  input  ctx_t             ctx_i,
  input  logic [3:0]       code_i,
  input  logic [MPS_W-1:0] rlen_i,
  output logic [1:0]       pid_o,
  output logic             tog_o,
  output logic [MPS_W-1:0] len_o,
  output ctx_t             ctx_o,
  output logic             fin_o,
  output logic [2:0]       stat_o,
  output logic             follow_o
);
  logic [LEN_W-1:0] mps_x, rlen_x, chunk;
  logic             stage_end;

  always_comb begin
    mps_x  = LEN_W'(ctx_i.mps);
    rlen_x = LEN_W'(rlen_i);
    chunk  = (ctx_i.rem < mps_x) ? ctx_i.rem : mps_x;
    unique case (ctx_i.phase)
      PH_SETUP: begin
        pid_o = PID_SETUP; tog_o = 1'b0; len_o = MPS_W'(SETUP_BYTES);
      end
      PH_STATUS: begin
        pid_o = (ctx_i.nodata || !ctx_i.dir_in) ? PID_IN : PID_OUT;
        tog_o = 1'b1; len_o = '0;
      end
      default: begin
        pid_o = ctx_i.dir_in ? PID_IN : PID_OUT;
        tog_o = ctx_i.toggle;
        len_o = ctx_i.dir_in ? ctx_i.mps : MPS_W'(chunk);
      end
    endcase
  end

  always_comb begin
    ctx_o = ctx_i; fin_o = 1'b0; stat_o = ST_OK; follow_o = 1'b0; stage_end = 1'b0;
    if (code_i == RC_ACK) begin
      ctx_o.errs   = '0;
      ctx_o.toggle = ~ctx_i.toggle;
      unique case (ctx_i.phase)
        PH_SETUP: begin
          ctx_o.toggle = 1'b1;
          ctx_o.phase  = ctx_i.nodata ? PH_STATUS : PH_DATA;
          follow_o     = 1'b1;
        end
        PH_STATUS: begin
          fin_o = 1'b1; ctx_o.active = 1'b0;
        end
        default: begin
          if (ctx_i.dir_in) begin
            stage_end = (rlen_x < mps_x) || (rlen_x >= ctx_i.rem);
            ctx_o.rem = (rlen_x >= ctx_i.rem) ? '0 : ctx_i.rem - rlen_x;
          end else begin
            stage_end = (ctx_i.rem == chunk);
            ctx_o.rem = ctx_i.rem - chunk;
          end
          if (stage_end) begin
            if (ctx_i.is_ctrl) begin
              ctx_o.phase = PH_STATUS; ctx_o.toggle = 1'b1;
            end else begin
              fin_o = 1'b1; ctx_o.active = 1'b0;
            end
          end
        end
      endcase
    end else if (code_i == RC_NAK) begin
      ctx_o.errs = '0;
      if (ctx_i.phase == PH_SETUP) begin
        fin_o = 1'b1; stat_o = ST_SETUPNAK; ctx_o.active = 1'b0;
      end
    end else if (code_i == RC_STALL) begin
      fin_o = 1'b1; stat_o = ST_STALL; ctx_o.active = 1'b0; ctx_o.halted = 1'b1;
    end else if (code_i == RC_TOGERR) begin
      ctx_o.errs = '0;
    end else if (int'(ctx_i.errs) + 1 >= ERR_LIMIT) begin
      fin_o = 1'b1; stat_o = ST_PROTO; ctx_o.active = 1'b0; ctx_o.halted = 1'b1;
      ctx_o.errs = '0;
    end else begin
      ctx_o.errs = ctx_i.errs + 1'b1;
    end
  end
endmodule

// File: rtl/ep_rr_sched.sv
module ep_rr_sched
  import ep_rr_sched_pkg::*;
#(
  parameter int N_EP      = 4,
  parameter int ERR_LIMIT = 3,
  parameter int EP_W      = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_op,
  input  logic [EP_W-1:0]  cmd_ep,
  input  logic             cmd_ctrl,
  input  logic             cmd_dir_in,
  input  logic             cmd_toggle,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [MPS_W-1:0] cmd_mps,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [EP_W-1:0]  req_ep,
  output logic [1:0]       req_pid,
  output logic             req_toggle,
  output logic [MPS_W-1:0] req_len,
  input  logic             res_valid,
  input  logic [3:0]       res_code,
  input  logic [MPS_W-1:0] res_len,
  output logic             done_valid,
  output logic [EP_W-1:0]  done_ep,
  output logic [2:0]       done_status,
  output logic [N_EP-1:0]  ep_halted
);
  typedef enum logic [1:0] {S_PICK, S_REQ, S_WAIT} st_e;

  st_e             state;
  logic [EP_W-1:0] cur, last, sel;
  ctx_t            ctx_w [N_EP];
  ctx_t            cur_ctx, nxt_ctx, loaded;
  logic [N_EP-1:0] act_vec, unl_pend, elig, unl_mask;
  logic            any, cmd_fire, busy, unl_now, unl_defer, res_take;
  logic            fin, follow;
  logic [2:0]      fin_stat;

  assign cur_ctx   = ctx_w[cur];
  assign busy      = (state != S_PICK);
  assign cmd_ready = !res_valid && ((cmd_op == OP_UNLINK) || !ctx_w[cmd_ep].active);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign unl_now   = cmd_fire && (cmd_op == OP_UNLINK) && ctx_w[cmd_ep].active
                     && !(busy && cmd_ep == cur);
  assign unl_defer = cmd_fire && (cmd_op == OP_UNLINK) && ctx_w[cmd_ep].active
                     && busy && cmd_ep == cur;
  assign unl_mask  = unl_now ? (N_EP'(1) << cmd_ep) : '0;
  assign elig      = act_vec & ~unl_mask;
  assign res_take  = (state == S_WAIT) && res_valid;
  assign req_valid = (state == S_REQ);
  assign req_ep    = cur;

  always_comb begin
    loaded         = '0;
    loaded.active  = 1'b1;
    loaded.is_ctrl = cmd_ctrl;
    loaded.dir_in  = cmd_dir_in;
    loaded.nodata  = (cmd_len == '0);
    loaded.toggle  = cmd_ctrl ? 1'b0 : cmd_toggle;
    loaded.phase   = cmd_ctrl ? PH_SETUP : PH_DATA;
    loaded.rem     = cmd_len;
    loaded.mps     = cmd_mps;
  end

  ep_rr_pick #(.N(N_EP), .IW(EP_W)) pick_i (
    .elig(elig), .last(last), .any(any), .sel(sel)
  );

  ep_rr_txn #(.ERR_LIMIT(ERR_LIMIT)) txn_i (
    .ctx_i(cur_ctx), .code_i(res_code), .rlen_i(res_len),
    .pid_o(req_pid), .tog_o(req_toggle), .len_o(req_len),
    .ctx_o(nxt_ctx), .fin_o(fin), .stat_o(fin_stat), .follow_o(follow)
  );

  for (genvar g = 0; g < N_EP; g++) begin : g_ep
    ctx_t r;
    logic pend;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r <= '0; pend <= 1'b0;
      end else if (res_take && cur == EP_W'(g)) begin
        if (pend) r.active <= 1'b0;
        else      r <= nxt_ctx;
        pend <= 1'b0;
      end else if (cmd_fire && cmd_ep == EP_W'(g)) begin
        if (cmd_op == OP_ENQ) r <= loaded;
        else if (unl_now)     r.active <= 1'b0;
        else if (unl_defer)   pend <= 1'b1;
      end
    end
    assign ctx_w[g]     = r;
    assign act_vec[g]   = r.active;
    assign unl_pend[g]  = pend;
    assign ep_halted[g] = r.halted;

    p_err_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r.active |-> (int'(r.errs) < ERR_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PICK; cur <= '0; last <= EP_W'(N_EP - 1);
    end else begin
      unique case (state)
        S_PICK: if (any) begin cur <= sel; state <= S_REQ; end
        S_REQ:  if (req_ready) state <= S_WAIT;
        default: if (res_valid) begin
          last  <= cur;
          state <= (follow && !unl_pend[cur]) ? S_REQ : S_PICK;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0; done_ep <= '0; done_status <= ST_OK;
    end else begin
      done_valid <= 1'b0;
      if (res_take) begin
        done_valid  <= unl_pend[cur] || fin;
        done_ep     <= cur;
        done_status <= unl_pend[cur] ? ST_UNLINKED : fin_stat;
      end else if (unl_now) begin
        done_valid  <= 1'b1;
        done_ep     <= cmd_ep;
        done_status <= ST_UNLINKED;
      end
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_ep) && $stable(req_pid)
                                && $stable(req_len) && $stable(req_toggle));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PICK) && (act_vec == '0) |=> !req_valid);

  p_halt_on_fatal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_status == ST_STALL || done_status == ST_PROTO)
    |-> ep_halted[done_ep] && !act_vec[done_ep]);

  p_setup_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_take && req_pid == PID_SETUP && res_code == RC_ACK && !unl_pend[cur]
    |=> req_valid && req_ep == $past(cur) && req_pid != PID_SETUP);
endmodule

// File: tb/ep_rr_sched_tb_top.sv
`timescale 1ns/1ps
module ep_rr_sched_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_op = 0, cmd_ctrl = 0, cmd_dir_in = 0, cmd_toggle = 0;
  logic [1:0]  cmd_ep = '0;
  logic [15:0] cmd_len = '0;
  logic [10:0] cmd_mps = '0;
  logic        cmd_ready, req_valid, req_toggle, done_valid;
  logic        req_ready = 0, res_valid = 0;
  logic [1:0]  req_ep, req_pid, done_ep;
  logic [10:0] req_len, res_len = '0;
  logic [3:0]  res_code = '0;
  logic [2:0]  done_status;
  logic [N-1:0] ep_halted;

  ep_rr_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_ep(cmd_ep), .cmd_ctrl(cmd_ctrl), .cmd_dir_in(cmd_dir_in), .cmd_toggle(cmd_toggle),
    .cmd_len(cmd_len), .cmd_mps(cmd_mps), .req_valid(req_valid), .req_ready(req_ready),
    .req_ep(req_ep), .req_pid(req_pid), .req_toggle(req_toggle), .req_len(req_len),
    .res_valid(res_valid), .res_code(res_code), .res_len(res_len), .done_valid(done_valid),
    .done_ep(done_ep), .done_status(done_status), .ep_halted(ep_halted)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not end, actual %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  // reference model, built from the requirements
  bit m_act[N], m_halt[N], m_ctrl[N], m_in[N], m_nod[N], m_tog[N], m_up[N];
  int m_ph[N], m_errs[N], m_rem[N], m_mps[N];
  int m_last = N - 1, m_cur = 0;
  bit m_follow = 0;
  bit c_pend = 0, c_op = 0, c_ctrl = 0, c_din = 0, c_tog = 0;
  int c_e = 0, c_len = 0, c_mps = 8;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit any_act();
    for (int i = 0; i < N; i++) if (m_act[i]) return 1;
    return 0;
  endfunction

  function automatic void m_load(int e, bit ctrl, bit din, bit tog, int len, int mps);
    m_act[e] = 1; m_halt[e] = 0; m_ctrl[e] = ctrl; m_in[e] = din; m_nod[e] = (len == 0);
    m_tog[e] = ctrl ? 0 : tog; m_ph[e] = ctrl ? 0 : 1; m_errs[e] = 0;
    m_rem[e] = len; m_mps[e] = mps; m_up[e] = 0;
  endfunction

  // drive one command at a negedge; busy says a transaction is in flight on m_cur
  task automatic send_cmd(bit op, int e, bit ctrl, bit din, bit tog, int len, int mps, bit busy);
    bit rdy, imm;
    rdy = (op == 1) || !m_act[e];
    cmd_valid = 1; cmd_op = op; cmd_ep = 2'(e); cmd_ctrl = ctrl; cmd_dir_in = din;
    cmd_toggle = tog; cmd_len = 16'(len); cmd_mps = 11'(mps);
    #1;
    chk("R11 cmd_ready", int'(cmd_ready), int'(rdy));
    @(negedge clk);
    cmd_valid = 0;
    imm = 0;
    if (rdy) begin
      if (op == 0) m_load(e, ctrl, din, tog, len, mps);
      else if (m_act[e]) begin
        if (busy && e == m_cur) m_up[e] = 1;
        else begin m_act[e] = 0; imm = 1; end
      end
    end
    chk("R9 done after unlink", int'(done_valid), int'(imm));
    if (imm) begin
      chk("R9 unlink ep", int'(done_ep), e);
      chk("R9 unlink status", int'(done_status), 4);
    end
  endtask

  task automatic idle_check(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R10 no request while idle", int'(req_valid), 0);
    end
  endtask

  // serve one transaction; rlen < 0 picks a random IN length
  task automatic step(input int code, input int rlen);
    int e, w, epid, etog, elen, dly, rl, stat;
    bit fin, fol, se;
    if (!any_act()) return;
    e = -1;
    if (m_follow) e = m_cur;
    else for (int k = 1; k <= N; k++) if (e < 0 && m_act[(m_last + k) % N]) e = (m_last + k) % N;
    w = 0;
    while (!req_valid && w < 20) begin @(negedge clk); w++; end
    chk(m_follow ? "R2 follow-on endpoint" : "R1 rotation endpoint", int'(req_ep), e);
    if (!req_valid) return;
    e = int'(req_ep); m_cur = e;
    if (m_ph[e] == 0) begin epid = 2; etog = 0; elen = 8; end
    else if (m_ph[e] == 2) begin epid = (m_nod[e] || !m_in[e]) ? 1 : 0; etog = 1; elen = 0; end
    else begin
      epid = m_in[e] ? 1 : 0; etog = m_tog[e];
      elen = m_in[e] ? m_mps[e] : ((m_rem[e] < m_mps[e]) ? m_rem[e] : m_mps[e]);
    end
    chk(m_follow ? "R2 follow-on pid" : "R5 pid", int'(req_pid), epid);
    chk("R4 toggle", int'(req_toggle), etog);
    chk("R5 length", int'(req_len), elen);
    dly = $urandom % 3;
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk("R12 request held", int'(req_valid) * 4 + int'(req_ep), 4 + e);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    if (c_pend) begin
      send_cmd(c_op, c_e, c_ctrl, c_din, c_tog, c_len, c_mps, 1);
      c_pend = 0;
    end
    rl = 0;
    if (epid == 1 && m_ph[e] == 1) rl = (rlen < 0) ? int'($urandom % (m_mps[e] + 1)) : rlen;
    res_valid = 1; res_code = 4'(code); res_len = 11'(rl);
    #1;
    chk("R11 cmd_ready low with result", int'(cmd_ready), 0);
    @(negedge clk);
    res_valid = 0;
    // model update
    fin = 0; fol = 0; stat = 0;
    if (m_up[e]) begin fin = 1; stat = 4; m_act[e] = 0; m_up[e] = 0; end
    else if (code == 0) begin
      m_errs[e] = 0;
      if (m_ph[e] == 0) begin m_tog[e] = 1; m_ph[e] = m_nod[e] ? 2 : 1; fol = 1; end
      else if (m_ph[e] == 2) begin fin = 1; m_act[e] = 0; end
      else begin
        m_tog[e] = !m_tog[e];
        if (m_in[e]) begin
          se = (rl < m_mps[e]) || (rl >= m_rem[e]);
          m_rem[e] = (rl >= m_rem[e]) ? 0 : m_rem[e] - rl;
        end else begin
          se = (m_rem[e] <= m_mps[e]);
          m_rem[e] = se ? 0 : m_rem[e] - m_mps[e];
        end
        if (se) begin
          if (m_ctrl[e]) begin m_ph[e] = 2; m_tog[e] = 1; end
          else begin fin = 1; m_act[e] = 0; end
        end
      end
    end else if (code == 1) begin
      m_errs[e] = 0;
      if (m_ph[e] == 0) begin fin = 1; stat = 3; m_act[e] = 0; end
    end else if (code == 2) begin fin = 1; stat = 1; m_act[e] = 0; m_halt[e] = 1; end
    else if (code == 3) m_errs[e] = 0;
    else begin
      m_errs[e]++;
      if (m_errs[e] >= 3) begin fin = 1; stat = 2; m_act[e] = 0; m_halt[e] = 1; m_errs[e] = 0; end
    end
    m_follow = fol; m_last = e;
    chk("R5 completion raised", int'(done_valid), int'(fin));
    if (fin) begin
      chk("R5 completion ep", int'(done_ep), e);
      case (stat)
        0: chk("R5 status ok", int'(done_status), stat);
        1: chk("R6 status stall", int'(done_status), stat);
        2: chk("R7 status protocol", int'(done_status), stat);
        3: chk("R3 status setup nak", int'(done_status), stat);
        default: chk("R9 status unlinked", int'(done_status), stat);
      endcase
    end
    for (int i = 0; i < N; i++) chk("R6 halted flag", int'(ep_halted[i]), int'(m_halt[i]));
  endtask

  task automatic pend(bit op, int e, bit ctrl, bit din, bit tog, int len, int mps);
    c_pend = 1; c_op = op; c_e = e; c_ctrl = ctrl; c_din = din; c_tog = tog; c_len = len; c_mps = mps;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 reset req_valid", int'(req_valid), 0);
    chk("R13 reset done_valid", int'(done_valid), 0);
    chk("R13 reset halted", int'(ep_halted), 0);
    idle_check(8);

    // bulk OUT ep1 interleaved with control IN ep2
    send_cmd(0, 1, 0, 0, 0, 20, 8, 0);
    pend(0, 2, 1, 1, 0, 16, 8);
    step(0, 0);            // ep1 OUT 8
    step(0, 0);            // ep2 SETUP
    step(1, 0);            // ep2 data follow-on NAK
    step(0, 0);            // ep1 OUT 8
    step(0, 8);            // ep2 IN full
    step(0, 0);            // ep1 OUT 4, done
    step(0, 3);            // ep2 IN short
    step(0, 0);            // ep2 status OUT, done
    idle_check(5);

    // consecutive errors, broken by a toggle mismatch
    send_cmd(0, 3, 0, 1, 1, 64, 16, 0);
    step(4, 0); step(3, 0); step(4, 0); step(5, 0); step(6, 0);
    chk("R7 halted after error run", int'(ep_halted[3]), 1);
    idle_check(3);
    send_cmd(0, 3, 0, 1, 0, 64, 16, 0);
    chk("R8 halted cleared by enqueue", int'(ep_halted[3]), 0);
    pend(1, 3, 0, 0, 0, 0, 8);
    step(0, 16);           // result discarded, unlinked
    idle_check(3);

    // SETUP NAK, then status-stage STALL on a zero-length control transfer
    send_cmd(0, 0, 1, 0, 0, 0, 8, 0);
    step(1, 0);
    send_cmd(0, 0, 1, 0, 0, 0, 8, 0);
    step(0, 0);
    step(2, 0);
    chk("R6 ep0 halted", int'(ep_halted[0]), 1);

    // immediate unlink, rejected enqueue, unlink of idle endpoint
    send_cmd(0, 1, 0, 0, 1, 100, 8, 0);
    pend(0, 2, 0, 0, 0, 50, 8);
    step(0, 0);
    pend(1, 1, 0, 0, 0, 0, 8);
    step(0, 0);
    pend(0, 2, 0, 1, 0, 10, 8);
    step(4, 0);
    pend(1, 3, 0, 0, 0, 0, 8);
    step(1, 0);

    // seeded random traffic
    for (int i = 0; i < 1500; i++) begin
      int r, code, e;
      if (!any_act()) begin
        idle_check(2);
        send_cmd(0, $urandom % N, ($urandom % 10) < 3, $urandom % 2, $urandom % 2,
                 $urandom % 40, 8 << ($urandom % 3), 0);
      end
      if (($urandom % 100) < 30) begin
        e = $urandom % N;
        if (m_act[e]) pend($urandom % 2, e, 0, 1, 0, 5, 8);
        else pend(($urandom % 5) == 0, e, ($urandom % 10) < 3, $urandom % 2, $urandom % 2,
                  $urandom % 40, 8 << ($urandom % 3));
      end
      r = $urandom % 100;
      if (r < 50) code = 0;
      else if (r < 65) code = 1;
      else if (r < 70) code = 3;
      else if (r < 73) code = 2;
      else code = 4 + ($urandom % 6);
      step(code, -1);
    end

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule